// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 64-bit virtual address into a physical address by walking up to four levels of translation tables in memory, with a 48-bit input address space and 4 KiB pages. The sixteen bits above bit 47 choose the starting table. All ones choose the upper-half base and all zeros choose the lower-half base. Any other pattern faults at once, with no memory access.

Each level fetches one 64-bit descriptor through a request/response read port. The descriptor says one of three things: continue to a deeper table, finish with a page or a block mapping, or fault. The walker returns one result pulse. It carries either the physical address, or a translation fault code that names the failing level, together with the faulting virtual address and the write-not-read flag of the access.

The walker handles one translation at a time. A requester offers an address while `busy` is low, then waits for the result pulse. The walk is a four-state machine:
- `ST_IDLE` accepts a request. It moves to `ST_ISSUE`, or straight to `ST_DONE` for a non-canonical address.
- `ST_ISSUE` drives the one-cycle descriptor read and moves to `ST_WAIT`.
- `ST_WAIT` holds until the response arrives. A table descriptor sends it back to `ST_ISSUE` at the next level. A page, a block or a fault sends it to `ST_DONE`.
- `ST_DONE` presents the result for one cycle and returns to `ST_IDLE`.

Top module: `xlat_walker`

## Requirements
- R1: When `req_vaddr[63:48]` is all ones, the first descriptor is read at `hi_base + 8*req_vaddr[47:39]`. When it is all zeros, the first descriptor is read at `lo_base + 8*req_vaddr[47:39]`.
- R2: The indices for levels 1, 2 and 3 are virtual address bits 38:30, 29:21 and 20:12. Each descriptor read goes to the current table base plus 8 times that index.
- R3: At levels 0 to 2, a descriptor with bits 1:0 = 2'b11 names the next table. Its base is descriptor bits 47:12 with twelve low zero bits, and descriptor bits 63:48 are ignored.
- R4: At level 3, a descriptor with bits 1:0 = 2'b11 is a page. The result address is {descriptor[47:12], vaddr[11:0]}.
- R5: A descriptor with bits 1:0 = 2'b01 is a block. At level 1 the result address is {descriptor[47:30], vaddr[29:0]}. At level 2 it is {descriptor[47:21], vaddr[20:0]}.
- R6: A descriptor with bit 0 clear, or with bits 1:0 = 2'b01 at level 0 or level 3, ends the walk with `res_fault`=1 and `res_status` = 6'b0001LL, where LL is the level number.
- R7: A non-canonical address (bits 63:48 neither all ones nor all zeros) faults with status 6'b000100. No memory read is made, and `res_valid` rises in the cycle after the request is accepted.
- R8: Every result reports the request's virtual address on `res_va` and its write flag on `res_wnr`. A successful result has `res_fault`=0 and `res_status`=0.
- R9: `busy` rises in the cycle after a request is accepted and stays high through the result cycle. A request offered while `busy` is high is ignored. At most one descriptor read is outstanding, and `res_valid` lasts exactly one cycle.
- R10: After reset, `busy`, `mem_req` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, accepted when busy is low |
| req_vaddr | input | 64 | Virtual address to translate |
| req_write | input | 1 | Access is a store |
| lo_base | input | 48 | Level-0 table base for the lower half |
| hi_base | input | 48 | Level-0 table base for the upper half |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle descriptor read request |
| mem_addr | output | 48 | Descriptor physical address |
| mem_rsp_valid | input | 1 | Descriptor read data valid |
| mem_rsp_data | input | 64 | Descriptor read data |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Result is a translation fault |
| res_pa | output | 48 | Translated physical address |
| res_status | output | 6 | Fault status code, zero on success |
| res_wnr | output | 1 | Write flag of the translated access |
| res_va | output | 64 | Virtual address of the translated access |

## Verification
The assertions assume that memory returns exactly one response per read request and never sends a response that nobody asked for. The assertions also assume that `req_valid` is the only way a walk starts. The bench memory model keeps to this: it answers each `mem_req` with a single `mem_rsp_valid` pulse one cycle later, and it returns zero, an invalid descriptor, for any address it does not hold. The tests drive a request for a single cycle while `busy` is low. The one deliberate exception is the request offered during a walk, which checks that it is ignored.

// File: rtl/xwalk_pkg.sv
package xwalk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        DK_FAULT,
        DK_TABLE,
        DK_LEAF
    } desc_kind_t;

    localparam logic [3:0] XLAT_FAULT_CLASS = 4'b0001;
endpackage

// File: rtl/va_region_sel.sv
module va_region_sel #(
    parameter int VA_W    = 64,
    parameter int IN_BITS = 48,
    parameter int PA_W    = 48
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [PA_W-1:0] lo_base,
    input  logic [PA_W-1:0] hi_base,
    output logic [PA_W-1:0] sel_base,
    output logic            canonical
);
    localparam int TOP_W = VA_W - IN_BITS;

    logic [TOP_W-1:0] top_bits;
    logic             all_ones;
    logic             all_zeros;

    assign top_bits  = vaddr[VA_W-1:IN_BITS];
    assign all_ones  = &top_bits;
    assign all_zeros = ~|top_bits;
    assign canonical = all_ones | all_zeros;
    assign sel_base  = all_ones ? hi_base : lo_base;
endmodule

// File: rtl/desc_decoder.sv
module desc_decoder
    import xwalk_pkg::*;
#(
    parameter int DESC_W    = 64,
    parameter int PA_W      = 48,
    parameter int IN_BITS   = 48,
    parameter int LEVELS    = 4,
    parameter int GRAN_BITS = 12,
    parameter int IDX_BITS  = 9,
    parameter int LVL_W     = 2
) (
    input  logic [DESC_W-1:0]  desc,
    input  logic [LVL_W-1:0]   level,
    input  logic [IN_BITS-1:0] va_low,
    output desc_kind_t         kind,
    output logic [PA_W-1:0]    next_base,
    output logic [PA_W-1:0]    leaf_pa
);
    logic [PA_W-1:0] span_mask [LEVELS];
    logic            block_ok  [LEVELS];

    // Per-level span of the address bits that pass through unchanged.
    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        localparam int LOW_BITS = GRAN_BITS + (LEVELS - 1 - g) * IDX_BITS;
        assign span_mask[g] = (PA_W'(1) << LOW_BITS) - PA_W'(1);
        assign block_ok[g]  = (g > 0) && (g < LEVELS - 1);
    end

    logic [PA_W-1:0] desc_pa;
    logic [PA_W-1:0] lvl_mask;

    assign desc_pa   = desc[PA_W-1:0];
    assign lvl_mask  = span_mask[level];
    assign next_base = desc_pa & ~span_mask[LEVELS-1];
    assign leaf_pa   = (desc_pa & ~lvl_mask) | (PA_W'(va_low) & lvl_mask);

    always_comb begin
        if (!desc[0]) begin
            kind = DK_FAULT;
        end else if (desc[1]) begin
            kind = (level == LVL_W'(LEVELS - 1)) ? DK_LEAF : DK_TABLE;
        end else begin
            kind = block_ok[level] ? DK_LEAF : DK_FAULT;
        end
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xwalk_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int IN_BITS   = 48,
    parameter int PA_W      = 48,
    parameter int DESC_W    = 64,
    parameter int GRAN_BITS = 12,
    parameter int LEVELS    = 4,
    parameter int ST_W      = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_write,
    input  logic [PA_W-1:0]   lo_base,
    input  logic [PA_W-1:0]   hi_base,
    output logic              busy,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [DESC_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic              res_fault,
    output logic [PA_W-1:0]   res_pa,
    output logic [ST_W-1:0]   res_status,
    output logic              res_wnr,
    output logic [VA_W-1:0]   res_va
);
    localparam int IDX_BITS = (IN_BITS - GRAN_BITS) / LEVELS;
    localparam int LVL_W    = $clog2(LEVELS);
    localparam int ENT_SH   = $clog2(DESC_W / 8);

    walk_state_t       state, state_nx;
    logic [LVL_W-1:0]  level_q;
    logic [VA_W-1:0]   va_q;
    logic              wnr_q;
    logic [PA_W-1:0]   tbl_q;
    logic [PA_W-1:0]   pa_q;
    logic              fault_q;
    logic [ST_W-1:0]   status_q;

    logic [PA_W-1:0]   sel_base;
    logic              canonical;
    desc_kind_t        kind;
    logic [PA_W-1:0]   next_base;
    logic [PA_W-1:0]   leaf_pa;
    logic [IDX_BITS-1:0] idx;

    va_region_sel #(.VA_W(VA_W), .IN_BITS(IN_BITS), .PA_W(PA_W)) u_region (
        .vaddr     (req_vaddr),
        .lo_base   (lo_base),
        .hi_base   (hi_base),
        .sel_base  (sel_base),
        .canonical (canonical)
    );

    desc_decoder #(
        .DESC_W(DESC_W), .PA_W(PA_W), .IN_BITS(IN_BITS), .LEVELS(LEVELS),
        .GRAN_BITS(GRAN_BITS), .IDX_BITS(IDX_BITS), .LVL_W(LVL_W)
    ) u_decode (
        .desc      (mem_rsp_data),
        .level     (level_q),
        .va_low    (va_q[IN_BITS-1:0]),
        .kind      (kind),
        .next_base (next_base),
        .leaf_pa   (leaf_pa)
    );

    // Index field for the current level: deeper levels use lower bits.
    assign idx = va_q[GRAN_BITS + (LEVELS - 1 - int'(level_q)) * IDX_BITS +: IDX_BITS];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (req_valid) state_nx = canonical ? ST_ISSUE : ST_DONE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT:  if (mem_rsp_valid) state_nx = (kind == DK_TABLE) ? ST_ISSUE : ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Walk context and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q  <= '0;
            va_q     <= '0;
            wnr_q    <= 1'b0;
            tbl_q    <= '0;
            pa_q     <= '0;
            fault_q  <= 1'b0;
            status_q <= '0;
        end else if (state == ST_IDLE && req_valid) begin
            va_q     <= req_vaddr;
            wnr_q    <= req_write;
            level_q  <= '0;
            tbl_q    <= sel_base;
            pa_q     <= '0;
            fault_q  <= !canonical;
            status_q <= canonical ? '0 : ST_W'({XLAT_FAULT_CLASS, LVL_W'(0)});
        end else if (state == ST_WAIT && mem_rsp_valid) begin
            unique case (kind)
                DK_TABLE: begin
                    tbl_q   <= next_base;
                    level_q <= level_q + LVL_W'(1);
                end
                DK_LEAF: begin
                    pa_q     <= leaf_pa;
                    fault_q  <= 1'b0;
                    status_q <= '0;
                end
                default: begin
                    pa_q     <= '0;
                    fault_q  <= 1'b1;
                    status_q <= ST_W'({XLAT_FAULT_CLASS, level_q});
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != ST_IDLE);
        mem_req    = (state == ST_ISSUE);
        mem_addr   = tbl_q + (PA_W'(idx) << ENT_SH);
        res_valid  = (state == ST_DONE);
        res_fault  = fault_q;
        res_pa     = pa_q;
        res_status = status_q;
        res_wnr    = wnr_q;
        res_va     = va_q;
    end
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk #(
    parameter int VA_W    = 64,
    parameter int IN_BITS = 48,
    parameter int ST_W    = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            busy,
    input logic            mem_req,
    input logic            res_valid,
    input logic            res_fault,
    input logic [ST_W-1:0] res_status
);
    logic noncanon;
    assign noncanon = !(&req_vaddr[VA_W-1:IN_BITS]) && (|req_vaddr[VA_W-1:IN_BITS]);

    // R9: a read is only issued inside a walk
    a_r9_read_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R9: one read outstanding, never back to back
    a_r9_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9: result is a one-cycle pulse, then the walker is free
    a_r9_result_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && !busy));

    // R9: a walk starts only from a request
    a_r9_start_on_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    // R7: non-canonical address faults at level 0 on the next cycle without a read
    a_r7_noncanon_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && noncanon) |=>
            (res_valid && res_fault && res_status == 6'b000100 && !mem_req));

    // R6: every fault carries the translation-fault class
    a_r6_fault_class: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_status[5:2] == 4'b0001));

    // R8: success reports a zero status
    a_r8_ok_status: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_fault) |-> (res_status == '0));
endmodule

bind xlat_walker xlat_walker_chk #(
    .VA_W(VA_W), .IN_BITS(IN_BITS), .ST_W(ST_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .busy       (busy),
    .mem_req    (mem_req),
    .res_valid  (res_valid),
    .res_fault  (res_fault),
    .res_status (res_status)
);

// File: tb/test_xlat_walker.sv
module test_xlat_walker;
    localparam int CLK_PERIOD = 10;
    localparam logic [47:0] LO_BASE = 48'h0_0001_0000;
    localparam logic [47:0] HI_BASE = 48'h0_0002_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        busy, mem_req, res_valid, res_fault, res_wnr;
    logic [47:0] mem_addr, res_pa;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic [5:0]  res_status;
    logic [63:0] res_va;

    int checks = 0;
    int failures = 0;

    logic [63:0] mem [logic [47:0]];
    logic [47:0] rd_log [8];
    int          rd_cnt = 0;

    // captured result
    logic        c_fault, c_wnr;
    logic [47:0] c_pa;
    logic [5:0]  c_status;
    logic [63:0] c_va;
    int          c_cycles;

    always #(CLK_PERIOD/2) clk = ~clk;

    xlat_walker i_xlat_walker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_write(req_write), .lo_base(LO_BASE), .hi_base(HI_BASE), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_fault(res_fault),
        .res_pa(res_pa), .res_status(res_status), .res_wnr(res_wnr), .res_va(res_va)
    );

    // Memory model: one response, one cycle after each request
    always @(posedge clk) begin
        mem_rsp_valid <= mem_req;
        if (mem_req) begin
            mem_rsp_data <= mem.exists(mem_addr) ? mem[mem_addr] : 64'h0;
            if (rd_cnt < 8) rd_log[rd_cnt] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkva(input logic [15:0] top, input int i0, input int i1,
                                         input int i2, input int i3, input logic [11:0] off);
        return {top, 9'(i0), 9'(i1), 9'(i2), 9'(i3), off};
    endfunction

    task automatic walk(input logic [63:0] va, input logic wr);
        @(negedge clk);
        rd_cnt    = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        c_cycles  = 1;
        while (!res_valid && c_cycles < 100) begin
            @(negedge clk);
            c_cycles++;
        end
        c_fault  = res_fault;
        c_pa     = res_pa;
        c_status = res_status;
        c_wnr    = res_wnr;
        c_va     = res_va;
    endtask

    task automatic t_reset;
        chk("R10 busy after reset", 64'(busy), 64'h0);
        chk("R10 mem_req after reset", 64'(mem_req), 64'h0);
        chk("R10 res_valid after reset", 64'(res_valid), 64'h0);
    endtask

    task automatic t_low_page;
        logic [63:0] va = mkva(16'h0000, 1, 2, 3, 4, 12'hABC);
        walk(va, 1'b0);
        chk("R1 low base level0 read", 64'(rd_log[0]), 64'h1_0008);
        chk("R2 level1 read", 64'(rd_log[1]), 64'h3_0010);
        chk("R2 level2 read", 64'(rd_log[2]), 64'h4_0018);
        chk("R3 level3 read via table", 64'(rd_log[3]), 64'h5_0020);
        chk("R2 read count", 64'(rd_cnt), 64'd4);
        chk("R4 page address", 64'(c_pa), 64'h1234_5ABC);
        chk("R8 ok status", {57'h0, c_fault, c_status}, 64'h0);
        chk("R8 va reported", c_va, va);
    endtask

    task automatic t_high_page;
        walk(mkva(16'hFFFF, 5, 0, 0, 0, 12'h010), 1'b1);
        chk("R1 high base level0 read", 64'(rd_log[0]), 64'h2_0028);
        chk("R3 next table ignores upper bits", 64'(rd_log[1]), 64'h8_0000);
        chk("R4 high page address", 64'(c_pa), 64'h9999_9010);
        chk("R8 wnr on success", 64'(c_wnr), 64'h1);
    endtask

    task automatic t_blocks;
        walk({16'h0, 9'd1, 9'd7, 30'h0ABC_DEF0}, 1'b0);
        chk("R5 level1 block address", 64'(c_pa), 64'hC0_4ABC_DEF0);
        chk("R5 level1 block reads", 64'(rd_cnt), 64'd2);
        walk({16'h0, 9'd1, 9'd2, 9'd9, 21'h1F_0F0F}, 1'b0);
        chk("R5 level2 block address", 64'(c_pa), 64'h3FFF_0F0F);
        chk("R5 level2 ok", 64'(c_fault), 64'h0);
    endtask

    task automatic t_faults;
        logic [63:0] va = mkva(16'h0000, 1, 2, 10, 0, 12'h000);
        walk(va, 1'b1);
        chk("R6 invalid at level2 status", {57'h0, c_fault, c_status}, 64'h46);
        chk("R8 fault va", c_va, va);
        chk("R8 fault wnr", 64'(c_wnr), 64'h1);
        walk(mkva(16'h0000, 3, 0, 0, 0, 12'h000), 1'b0);
        chk("R6 invalid at level0 status", {57'h0, c_fault, c_status}, 64'h44);
        chk("R8 fault read wnr", 64'(c_wnr), 64'h0);
        walk(mkva(16'h0000, 4, 0, 0, 0, 12'h000), 1'b0);
        chk("R6 block at level0 faults", {57'h0, c_fault, c_status}, 64'h44);
        walk(mkva(16'h0000, 1, 2, 3, 5, 12'h000), 1'b0);
        chk("R6 block type at level3 faults", {57'h0, c_fault, c_status}, 64'h47);
    endtask

    task automatic t_noncanon;
        walk(64'h0001_0000_0000_0000, 1'b1);
        chk("R7 noncanonical status", {57'h0, c_fault, c_status}, 64'h44);
        chk("R7 no memory read", 64'(rd_cnt), 64'd0);
        chk("R7 result next cycle", 64'(c_cycles), 64'd1);
        chk("R8 noncanonical wnr", 64'(c_wnr), 64'h1);
        walk(64'h8000_0000_0000_1000, 1'b0);
        chk("R7 top bit only", {57'h0, c_fault, c_status}, 64'h44);
    endtask

    task automatic t_busy;
        logic [63:0] va = mkva(16'h0000, 1, 2, 3, 4, 12'h123);
        @(negedge clk);
        rd_cnt    = 0;
        req_valid = 1'b1;
        req_vaddr = va;
        req_write = 1'b0;
        @(negedge clk);
        chk("R9 busy after accept", 64'(busy), 64'h1);
        req_vaddr = mkva(16'hFFFF, 5, 0, 0, 0, 12'h000);
        req_write = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!res_valid) @(negedge clk);
        chk("R9 busy in result cycle", 64'(busy), 64'h1);
        chk("R9 ignored request pa", 64'(res_pa), 64'h1234_5123);
        chk("R9 ignored request va", res_va, va);
        chk("R9 ignored request reads", 64'(rd_cnt), 64'd4);
        @(negedge clk);
        chk("R9 result one cycle", 64'(res_valid), 64'h0);
        chk("R9 idle after result", 64'(busy), 64'h0);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        mem[48'h1_0008] = 64'h0000_0000_0003_0003;
        mem[48'h3_0010] = 64'h0000_0000_0004_0003;
        mem[48'h4_0018] = 64'h0000_0000_0005_0003;
        mem[48'h5_0020] = 64'h0060_0000_1234_5003;
        mem[48'h5_0028] = 64'h0000_0000_1234_5001;
        mem[48'h1_0020] = 64'h0000_0000_4000_0001;
        mem[48'h2_0028] = 64'hFFF0_0000_0008_0003;
        mem[48'h8_0000] = 64'h0000_0000_0008_1003;
        mem[48'h8_1000] = 64'h0000_0000_0008_2003;
        mem[48'h8_2000] = 64'h0000_0000_9999_9003;
        mem[48'h3_0038] = 64'h0000_00C0_4000_0001;
        mem[48'h4_0048] = 64'h0000_0000_3FE0_1001;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_low_page();
        t_high_page();
        t_blocks();
        t_faults();
        t_noncanon();
        t_busy();
        finish_run();
    end
endmodule